// File: doc/BRIEF.md
# Windowed Multi-Hit TDC Capture

This block timestamps falling edges on a set of hit channels against a shared start pulse. It records them into one buffer per channel while a capture window is open. When the window closes it drains everything as a stream of 32-bit words. Each hit line and the start line arrive as eight phase samples per tick, taken 1 ns apart by an external oversampler. The block runs on a tick clock representing 8 ns. A time value is the whole ticks counted since the start tick, times eight, plus the sample phase of the edge.

A falling edge on the start samples begins a cycle. A second start inside the window throws the cycle away and begins again. A start that arrives while words are being drained is refused and flagged. Each channel keeps at most a fixed number of hits per cycle and raises its own full flag when it has to drop one. Readout sends one stop word per stored hit, then a single start word. Before the first word, a byte count for the whole stream is presented.

Top module: `tdc_win_cap`

## Requirements
- R1: A falling edge in `start_i` outside readout opens a capture window. In each sample vector bit 0 is the earliest sample, and an edge sits at the lowest index p whose sample is 0 while the one before it is 1 (the previous tick's bit 7 comes before bit 0). A hit seen k ticks after the start tick at phase p gets the time 8*(k-1)+p. Hits in the start tick itself are not stored.
- R2: The window register resets to 0x1F3F ticks and is loaded from `win_i` when `win_we_i` is high. A window of W ticks captures in the W ticks after the start tick, and readout begins in the tick after those.
- R3: A start edge during capture drops every stored hit, clears the full flags and restarts timing from zero.
- R4: Hit edges while idle or during readout are not stored and change no output word.
- R5: Each channel stores at most DEPTH hits per cycle. A hit beyond that is lost and sets that channel's bit of `full_o` until the next accepted start.
- R6: A start edge during readout is ignored for capture. It sets `merr_o` and leaves `trig_cnt_o` unchanged. `merr_o` clears at the next accepted start.
- R7: Stop word: bits[31:24]=0x00, bit23=0, bit22=channel full, bit21=last stored hit of the channel, bits[20:16]=channel number, bits[15:0]=hit time.
- R8: Start word: bit31=`merr_o` value, bits[30:28]=3'b001, bits[27:16]=0, bits[15:0]=start edge phase. It is always the final word of a cycle, and `vld_o` drops after it is taken.
- R9: Stop words come in ascending channel order, oldest hit first within a channel, and channels with no hits send nothing.
- R10: `len_o` equals 4*(stored hits+1). It is valid and constant whenever `len_vld_o` is high, which holds for the whole readout.
- R11: A word offered with `vld_o` high and `rdy_i` low is held unchanged in the next tick.
- R12: `trig_cnt_o` resets to 0 and rises by one for every accepted start edge, restarts included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock (8 ns tick) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_we_i | input | 1 | Load window register |
| win_i | input | WIN_W | Window length in ticks |
| start_i | input | 8 | Start line phase samples, bit 0 earliest |
| hit_i | input | NCH x 8 | Hit line phase samples per channel |
| rdy_i | input | 1 | Stream sink ready |
| dat_o | output | 32 | Stream word |
| vld_o | output | 1 | Stream word valid |
| len_o | output | 32 | Byte count of the readout |
| len_vld_o | output | 1 | Byte count valid |
| full_o | output | NCH | Per-channel overflow flags |
| merr_o | output | 1 | Start refused during readout |
| trig_cnt_o | output | CNT_W | Accepted start count |

## Verification
Sparse random hits over the long reset-default window show where the window closes and confirm that phase and tick are combined into the time. Dense random hits on a short window, drained with a randomly stalling sink, separate errors in channel ordering, skipping of empty channels and last-word marking from errors in holding words under back-pressure. Directed cases each isolate one path: a restart inside the window, a channel driven far past its depth, a window with no hits, a start fired during readout, and hits applied while idle or draining. They show whether discarding, capping, the refusal flag and the ignore rules act alone, without disturbing the words around them.

// File: rtl/tdc_cap_pkg.sv
package tdc_cap_pkg;

  localparam int PHASES = 8;
  localparam int FINE_W = 3;
  localparam int TIME_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_READ = 2'd2
  } cap_state_e;

  function automatic logic [31:0] mk_stop(logic full, logic last, logic [4:0] ch,
                                          logic [TIME_W-1:0] t);
    return {8'h00, 1'b0, full, last, ch, t};
  endfunction

  function automatic logic [31:0] mk_start(logic merr, logic [TIME_W-1:0] t);
    return {merr, 3'b001, 12'h000, t};
  endfunction

endpackage

// File: rtl/tdc_edge_det.sv
module tdc_edge_det #(
  parameter int PH = 8,
  parameter int FW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PH-1:0] samp_i,
  output logic          edge_o,
  output logic [FW-1:0] phase_o
);

  logic          prev_q;
  logic [PH:0]   chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= samp_i[PH-1];
  end

  assign chain = {samp_i, prev_q};

  // lowest falling position wins
  always_comb begin
    edge_o  = 1'b0;
    phase_o = '0;
    for (int i = PH - 1; i >= 0; i--) begin
      if (chain[i] && !chain[i+1]) begin
        edge_o  = 1'b1;
        phase_o = FW'(i);
      end
    end
  end

endmodule

// File: rtl/tdc_hit_buf.sv
module tdc_hit_buf #(
  parameter int DEPTH = 16,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdat_i,
  input  logic [AW-1:0] ridx_i,
  output logic [DW-1:0] rdat_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full_q;
  logic          room;

  assign room = cnt_q < CW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (wr_i) begin
      if (room) cnt_q  <= cnt_q + 1'b1;
      else      full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i && room) mem_q[cnt_q[AW-1:0]] <= wdat_i;
  end

  assign rdat_o = mem_q[ridx_i];
  assign cnt_o  = cnt_q;
  assign full_o = full_q;

endmodule

// File: rtl/tdc_win_cap.sv
module tdc_win_cap
  import tdc_cap_pkg::*;
#(
  parameter int          NCH     = 4,
  parameter int          DEPTH   = 16,
  parameter int          WIN_W   = 16,
  parameter logic [15:0] WIN_RST = 16'h1F3F,
  parameter int          CNT_W   = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       win_we_i,
  input  logic [WIN_W-1:0]           win_i,
  input  logic [PHASES-1:0]          start_i,
  input  logic [NCH-1:0][PHASES-1:0] hit_i,
  input  logic                       rdy_i,
  output logic [31:0]                dat_o,
  output logic                       vld_o,
  output logic [31:0]                len_o,
  output logic                       len_vld_o,
  output logic [NCH-1:0]             full_o,
  output logic                       merr_o,
  output logic [CNT_W-1:0]           trig_cnt_o
);

  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int CHW   = $clog2(NCH + 1);
  localparam int CRS_W = TIME_W - FINE_W;

  cap_state_e          state_q;
  logic [WIN_W-1:0]    win_q;
  logic [WIN_W-1:0]    coarse_q;
  logic [FINE_W-1:0]   st_fine_q;
  logic                merr_q;
  logic [CNT_W-1:0]    trig_q;
  logic [CHW-1:0]      rd_ch_q;
  logic [CW-1:0]       rd_idx_q;

  logic                st_edge;
  logic [FINE_W-1:0]   st_phase;
  logic                clr;
  logic [NCH-1:0]      h_edge;
  logic [FINE_W-1:0]   h_phase [NCH];
  logic [TIME_W-1:0]   rdat    [NCH];
  logic [CW-1:0]       cnt     [NCH];
  logic [NCH-1:0]      full;

  logic [CHW-1:0]      cur_ch;
  logic [CW-1:0]       sel_cnt;
  logic [TIME_W-1:0]   sel_dat;
  logic                sel_full;
  logic                stop_ph;
  logic                last;
  logic                win_end;
  logic [31:0]         tot;

  tdc_edge_det #(.PH(PHASES), .FW(FINE_W)) u_st_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .samp_i (start_i),
    .edge_o (st_edge),
    .phase_o(st_phase)
  );

  assign clr = st_edge && (state_q != ST_READ);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr;
    tdc_edge_det #(.PH(PHASES), .FW(FINE_W)) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .samp_i (hit_i[c]),
      .edge_o (h_edge[c]),
      .phase_o(h_phase[c])
    );
    assign wr = (state_q == ST_CAPT) && !st_edge && h_edge[c];
    tdc_hit_buf #(.DEPTH(DEPTH), .DW(TIME_W)) u_buf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .wr_i   (wr),
      .wdat_i ({coarse_q[CRS_W-1:0], h_phase[c]}),
      .ridx_i (rd_idx_q[AW-1:0]),
      .rdat_o (rdat[c]),
      .cnt_o  (cnt[c]),
      .full_o (full[c])
    );
  end

  // first non-empty channel at or above the read base
  always_comb begin
    cur_ch = CHW'(NCH);
    for (int i = NCH - 1; i >= 0; i--) begin
      if (CHW'(i) >= rd_ch_q && cnt[i] != '0) cur_ch = CHW'(i);
    end
  end

  always_comb begin
    sel_cnt  = '0;
    sel_dat  = '0;
    sel_full = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (cur_ch == CHW'(i)) begin
        sel_cnt  = cnt[i];
        sel_dat  = rdat[i];
        sel_full = full[i];
      end
    end
  end

  always_comb begin
    tot = '0;
    for (int i = 0; i < NCH; i++) tot = tot + 32'(cnt[i]);
  end

  assign stop_ph = cur_ch != CHW'(NCH);
  assign last    = (rd_idx_q + 1'b1) == sel_cnt;
  assign win_end = ((WIN_W+1)'(coarse_q) + 1'b1) >= (WIN_W+1)'(win_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      win_q     <= WIN_W'(WIN_RST);
      coarse_q  <= '0;
      st_fine_q <= '0;
      merr_q    <= 1'b0;
      trig_q    <= '0;
      rd_ch_q   <= '0;
      rd_idx_q  <= '0;
    end else begin
      if (win_we_i) win_q <= win_i;
      case (state_q)
        ST_READ: begin
          if (st_edge) merr_q <= 1'b1;
          if (rdy_i) begin
            if (stop_ph) begin
              if (last) begin
                rd_ch_q  <= cur_ch + 1'b1;
                rd_idx_q <= '0;
              end else begin
                rd_idx_q <= rd_idx_q + 1'b1;
              end
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: begin
          if (st_edge) begin
            state_q   <= ST_CAPT;
            coarse_q  <= '0;
            st_fine_q <= st_phase;
            merr_q    <= 1'b0;
            trig_q    <= trig_q + 1'b1;
          end else if (state_q == ST_CAPT) begin
            if (win_end) begin
              state_q  <= ST_READ;
              rd_ch_q  <= '0;
              rd_idx_q <= '0;
            end else begin
              coarse_q <= coarse_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign dat_o      = stop_ph ? mk_stop(sel_full, last, 5'(cur_ch), sel_dat)
                              : mk_start(merr_q, TIME_W'(st_fine_q));
  assign vld_o      = state_q == ST_READ;
  assign len_vld_o  = state_q == ST_READ;
  assign len_o      = (tot + 32'd1) << 2;
  assign full_o     = full;
  assign merr_o     = merr_q;
  assign trig_cnt_o = trig_q;

endmodule

// File: rtl/tdc_win_cap_chk.sv
module tdc_win_cap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rdy_i,
  input logic [31:0]      dat_o,
  input logic             vld_o,
  input logic [31:0]      len_o,
  input logic             len_vld_o,
  input logic             merr_o,
  input logic [CNT_W-1:0] trig_cnt_o
);

  // R11
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && !rdy_i && dat_o[31:24] == 8'h00 |=> vld_o && $stable(dat_o));

  // R8
  start_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o && rdy_i && dat_o[30:28] == 3'b001 |=> !vld_o);

  // R10
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_vld_o && $past(len_vld_o) |-> $stable(len_o));

  // R6
  trig_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_vld_o && $past(len_vld_o) |-> $stable(trig_cnt_o));

  // R6
  merr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(merr_o) |-> $past(len_vld_o));

  // R12
  trig_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trig_cnt_o) |-> trig_cnt_o == CNT_W'($past(trig_cnt_o) + 1'b1));

endmodule

bind tdc_win_cap tdc_win_cap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rdy_i     (rdy_i),
  .dat_o     (dat_o),
  .vld_o     (vld_o),
  .len_o     (len_o),
  .len_vld_o (len_vld_o),
  .merr_o    (merr_o),
  .trig_cnt_o(trig_cnt_o)
);

// File: tb/tdc_win_cap_bench.sv
module tdc_win_cap_bench;

  localparam int NCH   = 4;
  localparam int DEPTH = 16;
  localparam int WIN_W = 16;
  localparam int CNT_W = 16;

  logic                  clk_i = 1'b0;
  logic                  rst_ni = 1'b0;
  logic                  win_we_i = 1'b0;
  logic [WIN_W-1:0]      win_i = '0;
  logic [7:0]            start_i = 8'hFF;
  logic [NCH-1:0][7:0]   hit_i = '1;
  logic                  rdy_i = 1'b0;
  logic [31:0]           dat_o;
  logic                  vld_o;
  logic [31:0]           len_o;
  logic                  len_vld_o;
  logic [NCH-1:0]        full_o;
  logic                  merr_o;
  logic [CNT_W-1:0]      trig_cnt_o;

  tdc_win_cap #(.NCH(NCH), .DEPTH(DEPTH), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_tdc_win_cap (
    .clk_i, .rst_ni, .win_we_i, .win_i, .start_i, .hit_i, .rdy_i,
    .dat_o, .vld_o, .len_o, .len_vld_o, .full_o, .merr_o, .trig_cnt_o
  );

  always #10 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R1";

  // stimulus for the next tick
  int st_ph = -1;
  int hp [NCH];
  bit rdy = 0;
  bit we = 0;
  int wv = 0;
  bit prev_st = 0;
  bit prev_h [NCH];

  // reference model
  int m_state = 0;
  int m_coarse = 0;
  int m_win = 16'h1F3F;
  int m_stph = 0;
  bit m_merr = 0;
  int m_trig = 0;
  int m_cnt [NCH];
  int m_time [NCH][DEPTH];
  bit m_full [NCH];
  int m_rch = 0;
  int m_ridx = 0;
  bit entered = 0;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(int p);
    logic [7:0] ones = 8'hFF;
    if (p < 0) return 8'hFF;
    return ~(ones << p);
  endfunction

  function automatic bit pr(int pct);
    return ($urandom % 100) < pct;
  endfunction

  function automatic int cur_model_ch();
    for (int c = 0; c < NCH; c++)
      if (c >= m_rch && m_cnt[c] > 0) return c;
    return NCH;
  endfunction

  function automatic logic [31:0] exp_word();
    int ch = cur_model_ch();
    if (ch < NCH)
      return {8'h00, 1'b0, m_full[ch], (m_ridx + 1 == m_cnt[ch]), 5'(ch),
              16'(m_time[ch][m_ridx])};
    return {m_merr, 3'b001, 12'h000, 16'(m_stph)};
  endfunction

  function automatic logic [NCH-1:0] m_full_vec();
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = m_full[c];
    return v;
  endfunction

  function automatic int m_total();
    int s = 0;
    for (int c = 0; c < NCH; c++) s += m_cnt[c];
    return s;
  endfunction

  task automatic tick();
    bit hs;
    bit se;
    logic [22:0] act, exp;
    if (st_ph >= 0 && prev_st) st_ph = -1;
    for (int c = 0; c < NCH; c++) if (hp[c] >= 0 && prev_h[c]) hp[c] = -1;
    start_i = mk(st_ph);
    for (int c = 0; c < NCH; c++) hit_i[c] = mk(hp[c]);
    rdy_i = rdy;
    win_we_i = we;
    win_i = WIN_W'(wv);
    #2;
    act = {vld_o, len_vld_o, merr_o, full_o, trig_cnt_o};
    exp = {m_state == 2, m_state == 2, m_merr, m_full_vec(), CNT_W'(m_trig)};
    chk(act == exp, "R2 R5 R6 R12 state", 64'(act), 64'(exp));
    hs = vld_o && rdy_i;
    if (hs) chk(dat_o == exp_word(), "R1 R7 R8 R9 R11 word", 64'(dat_o), 64'(exp_word()));
    se = st_ph >= 0;
    entered = 0;
    if (m_state == 2) begin
      if (se) m_merr = 1;
      if (hs) begin
        int ch = cur_model_ch();
        if (ch < NCH) begin
          if (m_ridx + 1 == m_cnt[ch]) begin m_rch = ch + 1; m_ridx = 0; end
          else m_ridx++;
        end else m_state = 0;
      end
    end else if (se) begin
      for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_full[c] = 0; end
      m_state = 1; m_coarse = 0; m_stph = st_ph; m_merr = 0; m_trig++;
    end else if (m_state == 1) begin
      for (int c = 0; c < NCH; c++) begin
        if (hp[c] >= 0) begin
          if (m_cnt[c] < DEPTH) begin
            m_time[c][m_cnt[c]] = (m_coarse * 8 + hp[c]) & 16'hFFFF;
            m_cnt[c]++;
          end else m_full[c] = 1;
        end
      end
      if (m_coarse + 1 >= m_win) begin
        m_state = 2; m_rch = 0; m_ridx = 0; entered = 1;
      end else m_coarse++;
    end
    if (we) m_win = wv;
    prev_st = se;
    for (int c = 0; c < NCH; c++) prev_h[c] = hp[c] >= 0;
    @(posedge clk_i);
    @(negedge clk_i);
    if (entered)
      chk(len_vld_o && len_o == 32'(4 * (m_total() + 1)), {"R10 ", cur_tag},
          64'(len_o), 64'(4 * (m_total() + 1)));
    st_ph = -1;
    for (int c = 0; c < NCH; c++) hp[c] = -1;
    we = 0;
  endtask

  task automatic rand_hits(int prob);
    for (int c = 0; c < NCH; c++) hp[c] = pr(prob) ? int'($urandom % 8) : -1;
  endtask

  task automatic set_win(int v);
    we = 1; wv = v;
    tick();
  endtask

  task automatic drain(int rprob, int hprob, int st_at);
    int k = 0;
    while (m_state == 2) begin
      rdy = pr(rprob);
      rand_hits(hprob);
      if (k == st_at) st_ph = int'($urandom % 8);
      tick();
      k++;
    end
    rdy = 0;
  endtask

  task automatic capture(int hprob);
    while (m_state == 1) begin
      rand_hits(hprob);
      tick();
    end
  endtask

  task automatic run_cycle(int sph, int hprob, int rprob, int dhprob);
    st_ph = sph;
    tick();
    capture(hprob);
    drain(rprob, dhprob, -1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7211));
    for (int c = 0; c < NCH; c++) begin hp[c] = -1; prev_h[c] = 0; m_cnt[c] = 0; m_full[c] = 0; end
    repeat (3) @(negedge clk_i);
    chk(!vld_o && !len_vld_o && !merr_o && full_o == '0 && trig_cnt_o == '0,
        "R12 reset", 64'({vld_o, len_vld_o, merr_o, full_o, trig_cnt_o}), 64'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset-default window, sparse hits
    cur_tag = "R2";
    run_cycle(3, 2, 80, 0);

    // short window, dense random hits, random stalls
    cur_tag = "R1";
    set_win(20);
    for (int i = 0; i < 30; i++) run_cycle(int'($urandom % 8), 35, 60, 0);

    // R4: hits while idle and while draining
    cur_tag = "R4";
    for (int i = 0; i < 6; i++) begin rand_hits(60); tick(); end
    run_cycle(0, 30, 30, 70);

    // R3: restart inside the window
    cur_tag = "R3";
    st_ph = 1; tick();
    for (int i = 0; i < 10; i++) begin rand_hits(50); tick(); end
    tick();
    st_ph = 5; tick();
    capture(40);
    drain(70, 0, -1);

    // R5: one channel driven past its depth
    cur_tag = "R5";
    set_win(60);
    st_ph = 2; tick();
    while (m_state == 1) begin
      rand_hits(20);
      hp[2] = int'($urandom % 8);
      tick();
    end
    chk(full_o[2] == 1'b1, "R5 full flag", 64'(full_o), 64'(4));
    drain(50, 0, -1);

    // R9 R10: empty window
    cur_tag = "R9 empty";
    set_win(8);
    run_cycle(7, 0, 100, 0);

    // R6: start during readout
    cur_tag = "R6";
    set_win(20);
    st_ph = 4; tick();
    capture(40);
    drain(40, 0, 2);
    chk(merr_o == 1'b1, "R6 merr set", 64'(merr_o), 64'(1));
    run_cycle(6, 30, 90, 0);
    chk(merr_o == 1'b0, "R6 merr cleared", 64'(merr_o), 64'(0));

    repeat (2) tick();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule